// File: doc/BRIEF.md
# Pulse-Stretching Digital Phase-Locked Loop

This block regenerates a line-rate clock and a local 8 kHz frame signal and
keeps them phase-locked to an external 8 kHz reference. The design runs on a
single clock, `clk_2x`, that ticks at twice the master-clock rate. The master
clock is chosen a little faster than nominal, so an uncorrected local frame is
slightly shorter than a reference frame. A prescaler counts 16 ticks, which is
eight master periods, to make one line-clock period. A frame counter then
divides the line clock by `FRAME_DIV` to produce the local frame. Use 193 for
the 1.544 MHz line variant and 256 for the 2.048 MHz line variant.

The loop compares phase once per reference frame, at the active reference edge.
The parameter `LOCK_ON_FALLING` selects which edge is active. If the local frame
is running ahead of the reference, the loop slows it down. It does this by
holding the prescaler for one tick (half a master period) at two fixed frame
positions. This lengthens the frame by one master period. If the local frame is
lagging, ticks pass through unaltered, and the naturally fast master clock
closes the gap. If no reference edges arrive, the loop stops correcting and runs
free at exactly the divided master rate.

Top module: `pulse_stretch_dpll`

## Requirements
- R1: `line_clk` is low for 8 ticks and then high for 8 ticks. A line period lasts 16 ticks, or 17 ticks when it contains a stretch.
- R2: Between two rising edges of `frame_8k` there are `FRAME_DIV` line periods. `frame_8k` is high for the first `FRAME_DIV/2` line periods (integer division). With no stretches, a frame lasts exactly 16*`FRAME_DIV` ticks.
- R3: While `rst_n` is low, `line_clk` is 0, `frame_8k` is 1 and `locked` is 0. The first frame after release starts at line position 0 with no correction pending.
- R4: The reference passes through a two-stage synchronizer. Phase is compared only at an active edge. Once locked, each rising edge of `frame_8k` lies within 24 ticks of the latest active reference edge.
- R5: If an active edge arrives while the local line position is below `FRAME_DIV/2`, the loop enters slow mode. In slow mode, each stretch point holds the prescaler for one tick.
- R6: If an active edge arrives while the local line position is at or above `FRAME_DIV/2`, slow mode ends. Frames then last 16*`FRAME_DIV` ticks with no stretch.
- R7: Stretches occur only on the first tick of line position 0 or line position `FRAME_DIV/2`, and at most one per point. A frame therefore contains at most two stretches.
- R8: With `LOCK_ON_FALLING`=1, only the 1-to-0 transition of `ref_8k` is compared. Moving the 0-to-1 transition leaves lock and alignment unchanged.
- R9: `locked` rises after 4 consecutive active edges that arrive at line position 0 or `FRAME_DIV`-1. An active edge anywhere else clears `locked` and restarts the count.
- R10: After two consecutive local frames with no active edge, slow mode ends and `locked` clears. Frames then last 16*`FRAME_DIV` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Tick clock at twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_8k | input | 1 | 8 kHz reference, asynchronous to `clk_2x` |
| line_clk | output | 1 | Regenerated line-rate clock |
| frame_8k | output | 1 | Local 8 kHz frame signal, high in the first half of the frame |
| locked | output | 1 | Phase-lock indication |

## Verification
The assertions assume that `ref_8k` is a clean level with no glitches shorter than a few ticks. They also assume that at most one active edge arrives per local frame, so each comparison sees a fresh frame position. The stimulus drives `ref_8k` on the falling edge of the tick clock, with low pulses of 40 or 300 ticks. Its period is 16*`FRAME_DIV`+1 ticks, which lies between the free-running and the stretched frame lengths. The only exceptions are one deliberate half-frame phase jump and a long idle stretch with the reference held high.

// File: rtl/pspll_pkg.sv
package pspll_pkg;

    // Ticks of the 2x master clock that make one line-clock period
    // (eight master periods, two ticks each).
    localparam int unsigned TICKS_PER_LINE_DEF = 16;

    // Consecutive in-window comparisons needed before lock is declared.
    localparam int unsigned LOCK_FRAMES_DEF = 4;

    // Consecutive local frames without an active edge before the loop idles.
    localparam int unsigned MISS_FRAMES_DEF = 2;

endpackage

// File: rtl/pspll_prescaler.sv
module pspll_prescaler #(
    parameter int unsigned TICKS = pspll_pkg::TICKS_PER_LINE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_req_i,
    output logic line_clk_o,
    output logic line_tick_o,
    output logic stall_o
);

    localparam int unsigned W = $clog2(TICKS);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);
    localparam logic [W-1:0] HALF = W'(TICKS / 2);

    typedef struct packed {
        logic [W-1:0] ph;
        logic         stalled;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    stall;

    always_comb begin
        st_d  = st_q;
        // Hold one tick at the first tick of a requested line period, once.
        stall = stretch_req_i && (st_q.ph == '0) && !st_q.stalled;
        st_d.stalled = stall;
        if (!stall) begin
            st_d.ph = (st_q.ph == LAST) ? '0 : st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_clk_o  = (st_q.ph >= HALF);
    assign line_tick_o = !stall && (st_q.ph == LAST);
    assign stall_o     = stall;

    // R7: a stretch holds the counter at its start for exactly one tick
    a_r7_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (st_q.ph == '0) && !stall_o);

    // R1: the line clock is low right after a line period ends
    a_r1_low_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick_o |=> !line_clk_o);

endmodule

// File: rtl/pspll_frame_div.sv
module pspll_frame_div #(
    parameter int unsigned FRAME_DIV = 193
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_tick_i,
    output logic [$clog2(FRAME_DIV)-1:0] pos_o,
    output logic                         wrap_o,
    output logic                         stretch_point_o,
    output logic                         frame_o
);

    localparam int unsigned FW = $clog2(FRAME_DIV);
    localparam logic [FW-1:0] FLAST = FW'(FRAME_DIV - 1);
    localparam logic [FW-1:0] FHALF = FW'(FRAME_DIV / 2);

    typedef struct packed {
        logic [FW-1:0] pos;
    } fd_st_t;

    fd_st_t st_d, st_q;
    logic   wrap;

    always_comb begin
        st_d = st_q;
        wrap = line_tick_i && (st_q.pos == FLAST);
        if (line_tick_i) begin
            st_d.pos = wrap ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o           = st_q.pos;
    assign wrap_o          = wrap;
    assign stretch_point_o = (st_q.pos == '0) || (st_q.pos == FHALF);
    assign frame_o         = (st_q.pos < FHALF);

    // R2: the line position never leaves its range
    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= FLAST);

    // R2: a frame end restarts the line position at zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (pos_o == '0));

endmodule

// File: rtl/pspll_phase_det.sv
module pspll_phase_det #(
    parameter int unsigned FRAME_DIV       = 193,
    parameter bit          LOCK_ON_FALLING = 1'b1,
    parameter int unsigned LOCK_FRAMES     = pspll_pkg::LOCK_FRAMES_DEF,
    parameter int unsigned MISS_FRAMES     = pspll_pkg::MISS_FRAMES_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ref_i,
    input  logic [$clog2(FRAME_DIV)-1:0] pos_i,
    input  logic                         wrap_i,
    output logic                         slow_o,
    output logic                         locked_o
);

    localparam int unsigned FW = $clog2(FRAME_DIV);
    localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);
    localparam int unsigned MW = $clog2(MISS_FRAMES + 1);
    localparam logic [FW-1:0] FLAST = FW'(FRAME_DIV - 1);
    localparam logic [FW-1:0] FHALF = FW'(FRAME_DIV / 2);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic          slow;
        logic          seen;
        logic [CW-1:0] hits;
        logic [MW-1:0] miss;
        logic          locked;
    } pd_st_t;

    pd_st_t st_d, st_q;
    logic   act_edge;
    logic   in_window;
    logic   leading;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ref_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;

        act_edge  = LOCK_ON_FALLING ? (st_q.prev && !st_q.s2)
                                    : (!st_q.prev && st_q.s2);
        in_window = (pos_i == '0) || (pos_i == FLAST);
        leading   = (pos_i < FHALF);

        if (act_edge) begin
            st_d.slow = leading;
            st_d.seen = 1'b1;
            st_d.miss = '0;
            if (in_window) begin
                if (st_q.hits != CW'(LOCK_FRAMES)) begin
                    st_d.hits = st_q.hits + 1'b1;
                end
                if (st_q.hits >= CW'(LOCK_FRAMES - 1)) begin
                    st_d.locked = 1'b1;
                end
            end else begin
                st_d.hits   = '0;
                st_d.locked = 1'b0;
            end
        end else if (wrap_i) begin
            if (st_q.seen) begin
                st_d.seen = 1'b0;
            end else begin
                if (st_q.miss != MW'(MISS_FRAMES)) begin
                    st_d.miss = st_q.miss + 1'b1;
                end
                if (st_q.miss >= MW'(MISS_FRAMES - 1)) begin
                    st_d.slow   = 1'b0;
                    st_d.locked = 1'b0;
                    st_d.hits   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.s1   <= LOCK_ON_FALLING;
            st_q.s2   <= LOCK_ON_FALLING;
            st_q.prev <= LOCK_ON_FALLING;
        end else begin
            st_q <= st_d;
        end
    end

    assign slow_o   = st_q.slow;
    assign locked_o = st_q.locked;

    // R9: lock is only gained on an active edge inside the window
    a_r9_lock_on_window_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(act_edge && in_window));

    // R10: a saturated miss count never coexists with lock
    a_r10_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.miss == MW'(MISS_FRAMES)) |-> !locked_o);

endmodule

// File: rtl/pulse_stretch_dpll.sv
module pulse_stretch_dpll #(
    parameter int unsigned FRAME_DIV       = 193,
    parameter bit          LOCK_ON_FALLING = 1'b1,
    parameter int unsigned TICKS_PER_LINE  = pspll_pkg::TICKS_PER_LINE_DEF,
    parameter int unsigned LOCK_FRAMES     = pspll_pkg::LOCK_FRAMES_DEF,
    parameter int unsigned MISS_FRAMES     = pspll_pkg::MISS_FRAMES_DEF
) (
    input  logic clk_2x,
    input  logic rst_n,
    input  logic ref_8k,
    output logic line_clk,
    output logic frame_8k,
    output logic locked
);

    localparam int unsigned FW = $clog2(FRAME_DIV);
    localparam logic [FW-1:0] FHALF = FW'(FRAME_DIV / 2);

    logic          line_tick;
    logic          stall;
    logic          wrap;
    logic          at_point;
    logic          slow;
    logic [FW-1:0] pos;

    pspll_prescaler #(
        .TICKS (TICKS_PER_LINE)
    ) u_pre (
        .clk           (clk_2x),
        .rst_n         (rst_n),
        .stretch_req_i (slow && at_point),
        .line_clk_o    (line_clk),
        .line_tick_o   (line_tick),
        .stall_o       (stall)
    );

    pspll_frame_div #(
        .FRAME_DIV (FRAME_DIV)
    ) u_fdiv (
        .clk             (clk_2x),
        .rst_n           (rst_n),
        .line_tick_i     (line_tick),
        .pos_o           (pos),
        .wrap_o          (wrap),
        .stretch_point_o (at_point),
        .frame_o         (frame_8k)
    );

    pspll_phase_det #(
        .FRAME_DIV       (FRAME_DIV),
        .LOCK_ON_FALLING (LOCK_ON_FALLING),
        .LOCK_FRAMES     (LOCK_FRAMES),
        .MISS_FRAMES     (MISS_FRAMES)
    ) u_pd (
        .clk      (clk_2x),
        .rst_n    (rst_n),
        .ref_i    (ref_8k),
        .pos_i    (pos),
        .wrap_i   (wrap),
        .slow_o   (slow),
        .locked_o (locked)
    );

    // R7: a prescaler hold happens only at one of the two frame positions
    a_r7_stretch_position: assert property (@(posedge clk_2x) disable iff (!rst_n)
        stall |-> ((pos == '0) || (pos == FHALF)));

    // R5: a held tick never advances the frame position
    a_r5_hold_freezes_frame: assert property (@(posedge clk_2x) disable iff (!rst_n)
        stall |=> $stable(pos));

endmodule

// File: tb/pulse_stretch_dpll_bench.sv
module pulse_stretch_dpll_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 24;
    localparam int TPL        = 16;
    localparam int NOM        = DIV * TPL;
    localparam int REFP       = NOM + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_8k = 1'b1;
    logic line_clk, frame_8k, locked;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_stretch_dpll #(
        .FRAME_DIV       (DIV),
        .LOCK_ON_FALLING (1'b1)
    ) u_pulse_stretch_dpll (
        .clk_2x   (clk),
        .rst_n    (rst_n),
        .ref_8k   (ref_8k),
        .line_clk (line_clk),
        .frame_8k (frame_8k),
        .locked   (locked)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: scoreboard consumer and continuous waveform checks
    int  cyc = 0;
    int  t_line = 0, t_frise = 0, t_fedge = 0, t_reffall = 0;
    bit  have_line = 1'b0;
    bit  align_on = 1'b0;
    int  n_str = 0;
    int  seen_plain = 0, seen_str = 0;
    logic p_line = 1'b0, p_frame = 1'b1, p_ref = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; t_frise = 0; t_fedge = 0; have_line = 1'b0; n_str = 0;
            p_line = line_clk; p_frame = frame_8k; p_ref = ref_8k;
        end else begin
            cyc++;
            if (p_ref && !ref_8k) t_reffall = cyc;
            if (!p_frame && frame_8k) begin
                int per;
                per = cyc - t_frise;
                check(per == NOM + n_str, "R5/R6 frame length", per, NOM + n_str);
                check(n_str <= 2, "R7 stretches per frame", n_str, 2);
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(per == e, "R2/R10 free-run frame", per, e);
                end
                if (locked) begin
                    if (n_str == 0) seen_plain++;
                    else seen_str++;
                end
                if (align_on) begin
                    int d;
                    d = cyc - t_reffall;
                    if (d > REFP / 2) d = d - REFP;
                    check(d >= -24 && d <= 24, "R4 edge alignment", d, 0);
                end
                n_str = 0;
                t_frise = cyc;
                t_fedge = cyc;
            end
            if (p_frame && !frame_8k) t_fedge = cyc;
            if (!p_line && line_clk) begin
                if (have_line) begin
                    int lp;
                    lp = cyc - t_line;
                    check(lp == TPL || lp == TPL + 1, "R1 line period", lp, TPL);
                    if (lp == TPL + 1) begin
                        n_str++;
                        check(cyc - t_fedge <= TPL, "R7 stretch position",
                              cyc - t_fedge, TPL);
                    end
                end
                have_line = 1'b1;
                t_line = cyc;
            end
            if (p_line && !line_clk) begin
                check(cyc - t_line == TPL / 2, "R1 line high time", cyc - t_line, TPL / 2);
            end
            p_line = line_clk; p_frame = frame_8k; p_ref = ref_8k;
        end
    end

    // Driver: reference generation
    task automatic run_ref(input int frames, input int period, input int low_w);
        for (int f = 0; f < frames; f++) begin
            ref_8k <= 1'b0;
            repeat (low_w) @(negedge clk);
            ref_8k <= 1'b1;
            repeat (period - low_w) @(negedge clk);
        end
    endtask

    task automatic expect_free_frames(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(NOM);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R3: reset state
        check(line_clk == 1'b0, "R3 line_clk in reset", line_clk, 0);
        check(frame_8k == 1'b1, "R3 frame_8k in reset", frame_8k, 1);
        check(locked == 1'b0, "R3 locked in reset", locked, 0);
        rst_n <= 1'b1;

        // R2: reference held high, frames run free
        expect_free_frames(3);
        repeat (4 * NOM + 10) @(negedge clk);
        check(exp_q.size() == 0, "R2 free-run frames observed", exp_q.size(), 0);
        check(locked == 1'b0, "R2 no lock without reference", locked, 0);

        // R9: pull-in from a large offset, no early lock
        repeat (60) @(negedge clk);
        run_ref(5, REFP, 40);
        check(locked == 1'b0, "R9 no lock while far off", locked, 0);
        run_ref(80, REFP, 40);
        check(locked == 1'b1, "R9 lock after pull-in", locked, 1);

        // R4/R8: alignment, then move the inactive edge
        seen_plain = 0; seen_str = 0;
        align_on = 1'b1;
        run_ref(20, REFP, 40);
        run_ref(10, REFP, 300);
        check(locked == 1'b1, "R8 lock kept after duty change", locked, 1);
        align_on = 1'b0;
        check(seen_str > 0, "R5 stretched frames while locked", seen_str, 1);
        check(seen_plain > 0, "R6 plain frames while locked", seen_plain, 1);

        // R10: reference stops, lock drops, frames run free
        check(locked == 1'b1, "R10 locked before idle", locked, 1);
        repeat (4 * NOM) @(negedge clk);
        check(locked == 1'b0, "R10 lock cleared by idle", locked, 0);
        @(posedge frame_8k);
        @(negedge clk);
        expect_free_frames(2);
        repeat (2 * NOM + 20) @(negedge clk);
        check(exp_q.size() == 0, "R10 idle frames observed", exp_q.size(), 0);

        // R9: quick relock with the edge inside the window
        @(posedge frame_8k);
        repeat (5) @(negedge clk);
        run_ref(8, REFP, 40);
        check(locked == 1'b1, "R9 relock in window", locked, 1);

        // R9: a half-frame phase jump clears lock
        run_ref(1, REFP + NOM / 2, 40);
        ref_8k <= 1'b0;
        repeat (10) @(negedge clk);
        check(locked == 1'b0, "R9 out-of-window edge unlocks", locked, 0);
        ref_8k <= 1'b1;
        repeat (20) @(negedge clk);

        finish_run();
    end

endmodule